// File: doc/BRIEF.md
# Reloadable Watchdog Timer with Lockout

This block is a 16-bit up-counting watchdog for a CPU subsystem. A prescaler derived from the CPU clock advances the count either every 2 clocks or every 128 clocks. Software must service the timer before the count passes its maximum value. If it does not, the block raises a one-cycle internal-reset request and records the event in a sticky indication flag.

Three single-cycle strobes stand in for decoded instructions: service, disable and end-of-initialization. Servicing reloads the count from a programmable 8-bit value. It does not restart the count from zero: the count's upper byte takes the reload value and its lower byte is cleared. The disable strobe is honoured only in a short window after reset. That window closes for good, until the next reset, once the timer is serviced or initialization is declared complete.

The system reset generator drives two inputs, a system reset and a power-on reset. It is expected to assert the system reset in answer to the reset request.

Top module: `wdog_timer`

## Requirements
- R1: While `rst_n` or `por_n` is low at a clock edge, the count goes to 0x0000, the reset request goes low, the reload field and rate select go to 0 and counting is enabled. The lockout window is open after reset.
- R2: With rate select 0 the count rises by one every 2 clocks. After reset it reads floor(k/2) after k clock edges. After a service it reads reload×256 + floor(k/2) after k more edges.
- R3: With rate select 1 (control bit 0) the count rises by one every 128 clocks. After a service it reads reload×256 + floor(k/128) after k more edges.
- R4: The count wraps at the first step past 0xFFFF when no service arrives in that cycle. In the cycle after that step, `wdt_rst_o` is high for exactly one cycle, the count reads 0x0000 and the flag (control bit 1) reads 1.
- R5: A service strobe sets the count to reload×256 and restarts the prescaler. It also clears the flag. The reload used is the value stored before any write in the same cycle.
- R6: A disable strobe while the window is open stops the count. The count then holds its value until the next reset.
- R7: After a service strobe or an end-of-initialization strobe, disable strobes have no effect until the next reset.
- R8: A service strobe and a disable strobe in the same cycle perform the service, leave the timer counting and close the window.
- R9: The flag survives a low `rst_n`. It is cleared only by a service strobe or by `por_n` low. Control writes can neither set nor clear it.
- R10: The control read value holds the reload field in bits 15:8, the flag in bit 1 and the rate select in bit 0. Bits 7:2 read 0. A write stores bits 15:8 and bit 0.
- R11: The `idle_i` input has no effect: the count keeps advancing while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Synchronous active-low system reset (leaves the flag intact) |
| por_n | input | 1 | Synchronous active-low power-on reset (also clears the flag) |
| idle_i | input | 1 | System idle indication, ignored by the timer |
| svc_i | input | 1 | Service strobe |
| dis_i | input | 1 | Disable strobe |
| einit_i | input | 1 | End-of-initialization strobe |
| ctl_we | input | 1 | Control register write enable |
| ctl_wdata | input | 16 | Control register write data |
| ctl_rdata | output | 16 | Control register read data |
| cnt_o | output | 16 | Current count (read-only) |
| wdt_rst_o | output | 1 | One-cycle internal-reset request |

## Verification
The count is visible on every cycle, so a fault in the counter or its load path shows at the next service or tick. A prescaler fault shows as a wrong count within 2 or 128 clocks. The lockout window cannot be read directly. Its state appears only when a disable strobe is issued and the count is watched over the next few tens of cycles, so the bench probes it after each way of closing the window. A flag fault appears in the control read value in the cycle after an overflow, a reset or a service.

// File: rtl/wdog_pkg.sv
// Package: shared sizing for the watchdog timer.
// Assumes the count is split into an upper reload byte and a lower byte.
package wdog_pkg;
    localparam int CNT_W_DEF = 16;   // count width
    localparam int RLD_W_DEF = 8;    // reload field width (count's upper part)
    localparam int PRE_W_DEF = 7;    // prescaler width, slow rate = 2**PRE_W

    // Bit positions in the low part of the control register
    localparam int CTL_SLOW_BIT = 0;
    localparam int CTL_FLAG_BIT = 1;
endpackage

// File: rtl/wdog_prescaler.sv
// Module: wdog_prescaler
// Free-running divider. It makes a one-cycle tick every 2 clocks (slow_sel=0)
// or every 2**PRE_W clocks (slow_sel=1). A service restarts it from zero.
// Assumes synchronous active-low reset and PRE_W >= 2.
module wdog_prescaler #(
    parameter int PRE_W = wdog_pkg::PRE_W_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic slow_sel,
    output logic tick
);
    logic [PRE_W-1:0] pre_q;

    // Divider register: count up each clock, restart on clear or reset.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) pre_q <= '0;
        else               pre_q <= pre_q + 1'b1;
    end

    // Tick select: odd value for the fast rate, terminal value for the slow rate.
    always_comb begin
        tick = slow_sel ? (pre_q == {PRE_W{1'b1}}) : pre_q[0];
    end

    // Ticks are never back to back at either rate (R2, R3).
    p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    // A slow tick comes only after a full run of the divider (R3).
    p_slow_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (slow_sel && tick && !clr) |=> (pre_q == '0));
endmodule

// File: rtl/wdog_counter.sv
// Module: wdog_counter
// The watchdog count. It steps on a prescaler tick while running and loads
// reload×2**(CNT_W-RLD_W) on service. On a step past the maximum it flags an
// overflow event and registers a one-cycle reset request.
// Assumes a service takes priority over a tick in the same cycle.
module wdog_counter #(
    parameter int CNT_W = wdog_pkg::CNT_W_DEF,
    parameter int RLD_W = wdog_pkg::RLD_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             run,
    input  logic             svc,
    input  logic [RLD_W-1:0] reload,
    output logic [CNT_W-1:0] cnt,
    output logic             ovf_evt,
    output logic             rst_req
);
    localparam int LOW_W = CNT_W - RLD_W;

    logic [CNT_W-1:0] cnt_q;
    logic             req_q;

    // Overflow event: an unserviced step taken from the maximum count.
    always_comb begin
        ovf_evt = tick && run && !svc && (cnt_q == {CNT_W{1'b1}});
    end

    // Count register: service load first, then a step on tick while running.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt_q <= '0;
        else if (svc)          cnt_q <= {reload, {LOW_W{1'b0}}};
        else if (tick && run)  cnt_q <= cnt_q + 1'b1;
    end

    // Reset request: a one-cycle pulse following the overflow event.
    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= 1'b0;
        else        req_q <= ovf_evt;
    end

    assign cnt     = cnt_q;
    assign rst_req = req_q;

    // The request lasts exactly one cycle (R4).
    p_pulse_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
        req_q |=> !req_q);
    // The request coincides with the wrapped count (R4).
    p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        req_q |-> (cnt_q == '0));
    // A service loads the reload value into the upper part (R5).
    p_svc_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        svc |=> (cnt_q == {$past(reload), {LOW_W{1'b0}}}));
    // A stopped timer holds its count unless serviced (R6).
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !svc) |=> $stable(cnt_q));
endmodule

// File: rtl/wdog_ctrl.sv
// Module: wdog_ctrl
// Control register (reload field and rate select), the sticky reset
// indication flag, and the run/lockout state that decides whether a disable
// strobe is honoured. The flag has its own power-on reset, so a system reset
// leaves it intact.
// Assumes single-cycle strobes and synchronous active-low resets.
module wdog_ctrl #(
    parameter int CNT_W = wdog_pkg::CNT_W_DEF,
    parameter int RLD_W = wdog_pkg::RLD_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             por_n,
    input  logic             svc,
    input  logic             dis,
    input  logic             einit,
    input  logic             we,
    input  logic [CNT_W-1:0] wdata,
    input  logic             ovf_evt,
    output logic [CNT_W-1:0] rdata,
    output logic [RLD_W-1:0] reload,
    output logic             slow_sel,
    output logic             run
);
    localparam int LOW_W  = CNT_W - RLD_W;
    localparam int SLOW_B = wdog_pkg::CTL_SLOW_BIT;
    localparam int FLAG_B = wdog_pkg::CTL_FLAG_BIT;

    logic [RLD_W-1:0] reload_q;
    logic             slow_q;
    logic             flag_q;
    logic             win_q;
    logic             run_q;

    // Writable fields: reload value and rate select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_q <= '0;
            slow_q   <= 1'b0;
        end else if (we) begin
            reload_q <= wdata[CNT_W-1:LOW_W];
            slow_q   <= wdata[SLOW_B];
        end
    end

    // Sticky flag: set on overflow, cleared by service or power-on reset only.
    always_ff @(posedge clk) begin
        if (!por_n)       flag_q <= 1'b0;
        else if (ovf_evt) flag_q <= 1'b1;
        else if (svc)     flag_q <= 1'b0;
    end

    // Lockout window: open after reset, closed by service or end of init.
    always_ff @(posedge clk) begin
        if (!rst_n)             win_q <= 1'b1;
        else if (svc || einit)  win_q <= 1'b0;
    end

    // Run state: stopped only by a disable strobe inside the window, no service.
    always_ff @(posedge clk) begin
        if (!rst_n)                    run_q <= 1'b1;
        else if (dis && win_q && !svc) run_q <= 1'b0;
    end

    // Read value: reload field high, flag and rate select low, rest zero.
    always_comb begin
        rdata               = '0;
        rdata[CNT_W-1:LOW_W] = reload_q;
        rdata[FLAG_B]       = flag_q;
        rdata[SLOW_B]       = slow_q;
    end

    assign reload   = reload_q;
    assign slow_sel = slow_q;
    assign run      = run_q;

    // Once closed, the window stays closed until reset (R7).
    p_win_closed_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !win_q |=> !win_q);
    // A service in the same cycle as a disable keeps the timer running (R8).
    p_svc_beats_dis_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (svc && run_q) |=> run_q);
    // A write alone cannot change the flag (R9).
    p_flag_wr_r9: assert property (@(posedge clk) disable iff (!por_n)
        (we && !svc && !ovf_evt) |=> (flag_q == $past(flag_q)));
endmodule

// File: rtl/wdog_timer.sv
// Module: wdog_timer (top)
// Reloadable watchdog timer with a disable lockout. It ties together the
// prescaler, the count and the control/lockout logic. The idle input is
// accepted and ignored, so the timer keeps counting while the system idles.
// Assumes the system resets the block through rst_n after wdt_rst_o pulses.
module wdog_timer #(
    parameter int CNT_W = wdog_pkg::CNT_W_DEF,
    parameter int RLD_W = wdog_pkg::RLD_W_DEF,
    parameter int PRE_W = wdog_pkg::PRE_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             por_n,
    input  logic             idle_i,
    input  logic             svc_i,
    input  logic             dis_i,
    input  logic             einit_i,
    input  logic             ctl_we,
    input  logic [CNT_W-1:0] ctl_wdata,
    output logic [CNT_W-1:0] ctl_rdata,
    output logic [CNT_W-1:0] cnt_o,
    output logic             wdt_rst_o
);
    logic             sys_rst_n;
    logic             tick;
    logic             run;
    logic             slow_sel;
    logic             ovf_evt;
    logic [RLD_W-1:0] reload;
    logic             idle_unused;

    // Either reset returns the non-sticky state to its post-reset values.
    always_comb begin
        sys_rst_n   = rst_n && por_n;
        idle_unused = idle_i;
    end

    wdog_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk      (clk),
        .rst_n    (sys_rst_n),
        .clr      (svc_i),
        .slow_sel (slow_sel),
        .tick     (tick)
    );

    wdog_counter #(.CNT_W(CNT_W), .RLD_W(RLD_W)) u_cnt (
        .clk     (clk),
        .rst_n   (sys_rst_n),
        .tick    (tick),
        .run     (run),
        .svc     (svc_i),
        .reload  (reload),
        .cnt     (cnt_o),
        .ovf_evt (ovf_evt),
        .rst_req (wdt_rst_o)
    );

    wdog_ctrl #(.CNT_W(CNT_W), .RLD_W(RLD_W)) u_ctl (
        .clk      (clk),
        .rst_n    (sys_rst_n),
        .por_n    (por_n),
        .svc      (svc_i),
        .dis      (dis_i),
        .einit    (einit_i),
        .we       (ctl_we),
        .wdata    (ctl_wdata),
        .ovf_evt  (ovf_evt),
        .rdata    (ctl_rdata),
        .reload   (reload),
        .slow_sel (slow_sel),
        .run      (run)
    );

    // A reset request is always accompanied by the set flag (R4).
    p_flag_on_req_r4: assert property (@(posedge clk) disable iff (!sys_rst_n)
        wdt_rst_o |-> ctl_rdata[wdog_pkg::CTL_FLAG_BIT]);
    // Reset leaves the count at zero and no request pending (R1).
    p_reset_state_r1: assert property (@(posedge clk) disable iff (!por_n)
        !rst_n |=> (cnt_o == '0 && !wdt_rst_o));
endmodule

// File: tb/tb_wdog_timer.sv
// Bench for wdog_timer: a vector table of reload/rate/wait/expected count,
// then directed tests for reset, lockout, overflow and the sticky flag.
module tb_wdog_timer;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYC = 150000;

    typedef struct packed {
        logic [7:0]  rld;
        logic        slow;
        logic [15:0] wait_n;
        logic [15:0] exp;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VEC [NVEC] = '{
        '{8'h0C, 1'b0, 16'd10,  16'h0C05},
        '{8'h80, 1'b0, 16'd1,   16'h8000},
        '{8'h33, 1'b1, 16'd127, 16'h3300},
        '{8'h33, 1'b1, 16'd128, 16'h3301},
        '{8'h01, 1'b1, 16'd300, 16'h0102},
        '{8'hFE, 1'b0, 16'd7,   16'hFE03}
    };

    logic        clk = 1'b0;
    logic        rst_n, por_n, idle_i, svc_i, dis_i, einit_i, ctl_we;
    logic [15:0] ctl_wdata, ctl_rdata, cnt_o;
    logic        wdt_rst_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    logic [15:0] held;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdog_timer dut (
        .clk(clk), .rst_n(rst_n), .por_n(por_n), .idle_i(idle_i),
        .svc_i(svc_i), .dis_i(dis_i), .einit_i(einit_i),
        .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
        .cnt_o(cnt_o), .wdt_rst_o(wdt_rst_o)
    );

    task automatic wait_edges(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reset for three edges; por selects a power-on reset as well.
    task automatic do_reset(input bit por);
        rst_n = 1'b0;
        if (por) por_n = 1'b0;
        wait_edges(3);
        rst_n = 1'b1;
        por_n = 1'b1;
    endtask

    task automatic ctl_write(input logic [15:0] d);
        ctl_we = 1'b1; ctl_wdata = d;
        wait_edges(1);
        ctl_we = 1'b0;
    endtask

    task automatic service();
        svc_i = 1'b1;
        wait_edges(1);
        svc_i = 1'b0;
    endtask

    // Write reload FF, service, run 512 edges to the overflow.
    task automatic run_to_overflow();
        ctl_write(16'hFF00);
        service();
        wait_edges(511);
        check("R4 count at max", cnt_o, 16'hFFFF);
        check("R4 no request before wrap", {15'd0, wdt_rst_o}, 16'd0);
        wait_edges(1);
        check("R4 request pulse", {15'd0, wdt_rst_o}, 16'd1);
        check("R4 count wrapped", cnt_o, 16'h0000);
        check("R4 flag set", ctl_rdata, 16'hFF02);
        wait_edges(1);
        check("R4 request one cycle", {15'd0, wdt_rst_o}, 16'd0);
    endtask

    initial begin
        rst_n = 1'b0; por_n = 1'b0; idle_i = 1'b0; svc_i = 1'b0;
        dis_i = 1'b0; einit_i = 1'b0; ctl_we = 1'b0; ctl_wdata = '0;
        wait_edges(1);
        do_reset(1'b1);

        // R1: reset state
        check("R1 count", cnt_o, 16'h0000);
        check("R1 control", ctl_rdata, 16'h0000);
        check("R1 request", {15'd0, wdt_rst_o}, 16'd0);

        // R2 and R11: fast rate, idle held high
        idle_i = 1'b1;
        wait_edges(10);
        check("R2 R11 fast count with idle", cnt_o, 16'd5);
        idle_i = 1'b0;

        // R10: field layout, unused bits read zero, flag bit not writable
        ctl_write(16'hA5FF);
        check("R10 readback", ctl_rdata, 16'hA501);

        // R6: disable inside the window stops the count
        do_reset(1'b0);
        wait_edges(4);
        dis_i = 1'b1;
        wait_edges(1);
        dis_i = 1'b0;
        held = cnt_o;
        wait_edges(20);
        check("R6 count held", cnt_o, held);

        // R7: end of init closes the window
        do_reset(1'b0);
        einit_i = 1'b1;
        wait_edges(1);
        einit_i = 1'b0; dis_i = 1'b1;
        wait_edges(1);
        dis_i = 1'b0;
        wait_edges(18);
        check("R7 disable ignored after init", cnt_o, 16'd10);

        // R7: service closes the window
        do_reset(1'b0);
        service();
        dis_i = 1'b1;
        wait_edges(1);
        dis_i = 1'b0;
        wait_edges(18);
        check("R7 disable ignored after service", cnt_o, 16'd9);

        // R8: service and disable together, then a late disable
        do_reset(1'b0);
        ctl_write(16'h1000);
        svc_i = 1'b1; dis_i = 1'b1;
        wait_edges(1);
        svc_i = 1'b0;
        check("R8 service performed", cnt_o, 16'h1000);
        wait_edges(1);
        dis_i = 1'b0;
        wait_edges(11);
        check("R8 still counting", cnt_o, 16'h1006);

        // R5: write and service together use the old reload
        ctl_write(16'h2200);
        ctl_we = 1'b1; ctl_wdata = 16'h7700; svc_i = 1'b1;
        wait_edges(1);
        ctl_we = 1'b0; svc_i = 1'b0;
        check("R5 old reload used", cnt_o, 16'h2200);

        // R4: overflow
        do_reset(1'b1);
        run_to_overflow();

        // R9: flag survives a system reset, writes leave it alone
        do_reset(1'b0);
        check("R9 flag after system reset", ctl_rdata, 16'h0002);
        ctl_write(16'h0000);
        check("R9 write cannot clear", ctl_rdata, 16'h0002);
        service();
        check("R9 R5 service clears flag", ctl_rdata, 16'h0000);
        do_reset(1'b0);
        run_to_overflow();
        do_reset(1'b1);
        check("R9 power-on clears flag", ctl_rdata, 16'h0000);
        ctl_write(16'h0002);
        check("R9 write cannot set", ctl_rdata, 16'h0000);

        // R2 R3 R5: table of reload, rate, wait and expected count
        do_reset(1'b1);
        for (int i = 0; i < NVEC; i++) begin
            ctl_write({VEC[i].rld, 7'd0, VEC[i].slow});
            service();
            wait_edges(int'(VEC[i].wait_n));
            check(VEC[i].slow ? "R3 R5 slow vector" : "R2 R5 fast vector",
                  cnt_o, VEC[i].exp);
        end

        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (WATCHDOG_CYC) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule